// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block is the receive-side character buffer of a 16550-class serial port. The serial receiver pushes each assembled character with three status tags: parity error, framing error and break. It also flags a stop-bit glitch, which is stored as a framing error. The register side pops characters one at a time. For the entry at the read position, the block shows its tags so that the line-status register can report them.

A sticky summary flag reports that at least one tagged character has been in the queue. It stays set until a line-status read finds no tagged character left. A separate overrun flag records that a character arrived while the queue was full. That character is discarded, and the flag clears on a line-status read. A synchronous flush input empties the queue in one cycle.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: The queue holds at most DEPTH (default 16) characters. `level_o` reports occupancy, and a push is accepted only while occupancy is DEPTH-1 or less.
- R2: A push while `level_o` equals DEPTH, with no flush in the same cycle, is discarded. The stored contents are unchanged and `overrun_o` is 1 on the next cycle.
- R3: Characters leave in arrival order. A pop accepted on one cycle places the oldest character on `pop_data_o` at the following cycle.
- R4: The stored framing tag is the OR of `push_frm_i` and `push_glitch_i`.
- R5: `flush_i` makes `level_o` 0 on the next cycle and takes priority over a push or pop in the same cycle. It leaves `overrun_o` and `fifo_err_o` untouched.
- R6: An accepted push with any tag set makes `fifo_err_o` 1 on the next cycle.
- R7: `fifo_err_o` falls only on the cycle after a `stat_rd_i`, and only if no tagged character remains once that cycle's push, pop or flush is applied. Otherwise it stays at 1.
- R8: `head_par_o`, `head_frm_o` and `head_brk_o` show the tags of the character at the read position. All three are 0 while the queue is empty.
- R9: A pop while the queue is empty changes neither `level_o` nor `pop_data_o`.
- R10: A push and a pop in the same cycle, with the queue neither empty nor full, leave `level_o` unchanged.
- R11: `overrun_o` returns to 0 on the cycle after a `stat_rd_i`, unless a discarded push occurs in that same cycle.
- R12: After reset, `level_o`, `pop_data_o`, `overrun_o`, `fifo_err_o` and the head tags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous queue clear |
| push_i | input | 1 | Character write strobe from the receiver |
| push_data_i | input | DATA_W | Character to store |
| push_par_i | input | 1 | Parity error tag of the character |
| push_frm_i | input | 1 | Framing error tag of the character |
| push_glitch_i | input | 1 | Stop-bit glitch, stored as a framing error |
| push_brk_i | input | 1 | Break tag of the character |
| pop_i | input | 1 | Character read strobe from the register side |
| stat_rd_i | input | 1 | Line-status read strobe |
| pop_data_o | output | DATA_W | Last character popped |
| head_par_o | output | 1 | Parity tag at the read position |
| head_frm_o | output | 1 | Framing tag at the read position |
| head_brk_o | output | 1 | Break tag at the read position |
| level_o | output | $clog2(DEPTH)+1 | Occupancy |
| overrun_o | output | 1 | Sticky overrun flag |
| fifo_err_o | output | 1 | Sticky summary of tagged characters in the queue |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled at the clock. They also assume reset is held for at least one edge, and that tags only carry meaning when a push is accepted. The stimulus raises strobes only between edges and fills and drains the queue with biased random pushes and pops. It applies flushes and status reads rarely, so that the full, empty, overrun and summary-clear corners each occur many times.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef struct packed {
      logic par;
      logic frm;
      logic brk;
   } rxq_tag_t;

   function automatic logic tag_any(input rxq_tag_t t);
      return t.par | t.frm | t.brk;
   endfunction
endpackage

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
   parameter int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   output logic             wr_ok,
   output logic             rd_ok,
   output logic             full,
   output logic             empty,
   output logic [AW-1:0]    waddr,
   output logic [AW-1:0]    raddr,
   output logic [CNT_W-1:0] level
);
   logic [CNT_W-1:0] wptr_q, rptr_q;

   assign level = wptr_q - rptr_q;
   assign full  = (level == CNT_W'(DEPTH));
   assign empty = (level == '0);
   assign wr_ok = push && !full && !flush;
   assign rd_ok = pop && !empty && !flush;
   assign waddr = wptr_q[AW-1:0];
   assign raddr = rptr_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (flush) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (wr_ok) wptr_q <= wptr_q + 1'b1;
         if (rd_ok) rptr_q <= rptr_q + 1'b1;
      end
   end

   // R1: occupancy never exceeds capacity
   a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));
   // R5: flush empties the queue
   a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));
   // R10: push with pop in the middle range keeps the level
   a_r10_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !flush && !full && !empty) |=> $stable(level));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  rxq_tag_t          wtag,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output rxq_tag_t          head_tag,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] dat_q [DEPTH];
   rxq_tag_t          tag_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            dat_q[i] <= '0;
            tag_q[i] <= '0;
         end
      end else if (we) begin
         dat_q[waddr] <= wdata;
         tag_q[waddr] <= wtag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_data <= '0;
      else if (re) rd_data <= dat_q[raddr];
   end

   assign head_tag = tag_q[raddr];
endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic push,
   input  logic full,
   input  logic wr_ok,
   input  logic wr_tagged,
   input  logic rd_ok,
   input  logic head_tagged,
   input  logic stat_rd,
   output logic overrun,
   output logic err_any
);
   logic [CNT_W-1:0] tcnt_q, tcnt_d;
   logic             drop;

   assign drop = push && full && !flush;

   always_comb begin
      if (flush) tcnt_d = '0;
      else tcnt_d = tcnt_q + CNT_W'(wr_ok && wr_tagged) - CNT_W'(rd_ok && head_tagged);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q  <= '0;
         err_any <= 1'b0;
         overrun <= 1'b0;
      end else begin
         tcnt_q <= tcnt_d;
         if (wr_ok && wr_tagged)             err_any <= 1'b1;
         else if (stat_rd && tcnt_d == '0)   err_any <= 1'b0;
         if (drop)         overrun <= 1'b1;
         else if (stat_rd) overrun <= 1'b0;
      end
   end

   // R2: a dropped character raises overrun
   a_r2_drop_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> overrun);
   // R11: status read clears overrun when nothing is dropped
   a_r11_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !drop) |=> !overrun);
   // R6: a tagged character raises the summary flag
   a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_tagged) |=> err_any);
   // R7: the summary flag only falls after a status read
   a_r7_err_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_any) |-> $past(stat_rd));
   // R7: tagged entries held imply the summary flag
   a_r7_err_held: assert property (@(posedge clk) disable iff (!rst_n)
      (tcnt_q != '0) |-> err_any);
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              push_par_i,
   input  logic              push_frm_i,
   input  logic              push_glitch_i,
   input  logic              push_brk_i,
   input  logic              pop_i,
   input  logic              stat_rd_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              head_par_o,
   output logic              head_frm_o,
   output logic              head_brk_o,
   output logic [CNT_W-1:0]  level_o,
   output logic              overrun_o,
   output logic              fifo_err_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxq_tagged_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rxq_tagged_fifo: DATA_W must be positive");
      end
   endgenerate

   logic          wr_ok, rd_ok, full, empty;
   logic [AW-1:0] waddr, raddr;
   rxq_tag_t      wtag, htag_raw, htag;

   assign wtag.par = push_par_i;
   assign wtag.frm = push_frm_i | push_glitch_i;
   assign wtag.brk = push_brk_i;

   rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .flush(flush_i), .push(push_i), .pop(pop_i),
      .wr_ok(wr_ok), .rd_ok(rd_ok), .full(full), .empty(empty),
      .waddr(waddr), .raddr(raddr), .level(level_o)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(waddr), .wdata(push_data_i),
      .wtag(wtag), .re(rd_ok), .raddr(raddr), .head_tag(htag_raw), .rd_data(pop_data_o)
   );

   assign htag       = empty ? '0 : htag_raw;
   assign head_par_o = htag.par;
   assign head_frm_o = htag.frm;
   assign head_brk_o = htag.brk;

   rxq_err_track #(.DEPTH(DEPTH)) u_err (
      .clk(clk), .rst_n(rst_n), .flush(flush_i), .push(push_i), .full(full),
      .wr_ok(wr_ok), .wr_tagged(tag_any(wtag)), .rd_ok(rd_ok),
      .head_tagged(tag_any(htag)), .stat_rd(stat_rd_i),
      .overrun(overrun_o), .err_any(fifo_err_o)
   );

   // R9: popping an empty queue leaves the output character alone
   a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && level_o == '0 && !flush_i) |=> $stable(pop_data_o));
   // R8: no tags are shown while empty
   a_r8_empty_tags: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o == '0) |-> !(head_par_o || head_frm_o || head_brk_o));
endmodule

// File: tb/rxq_tagged_fifo_tb_top.sv
module rxq_tagged_fifo_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       flush_i, push_i, push_par_i, push_frm_i, push_glitch_i, push_brk_i;
   logic       pop_i, stat_rd_i;
   logic [7:0] push_data_i, pop_data_o;
   logic       head_par_o, head_frm_o, head_brk_o, overrun_o, fifo_err_o;
   logic [4:0] level_o;

   int n_tests = 0;
   int n_fail  = 0;

   // reference model
   logic [7:0] mq_d [16];
   logic [2:0] mq_t [16];   // {par, frm, brk}
   int         m_cnt, m_tcnt;
   logic       m_err, m_ovr;
   logic [7:0] m_rdd;

   always #2 clk = ~clk;

   rxq_tagged_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .push_i(push_i),
      .push_data_i(push_data_i), .push_par_i(push_par_i), .push_frm_i(push_frm_i),
      .push_glitch_i(push_glitch_i), .push_brk_i(push_brk_i), .pop_i(pop_i),
      .stat_rd_i(stat_rd_i), .pop_data_o(pop_data_o), .head_par_o(head_par_o),
      .head_frm_o(head_frm_o), .head_brk_o(head_brk_o), .level_o(level_o),
      .overrun_o(overrun_o), .fifo_err_o(fifo_err_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_head();
      return (m_cnt > 0) ? mq_t[0] : 3'b000;
   endfunction

   task automatic check_all();
      check("R1 level", int'(level_o), m_cnt);
      check("R3 pop data", int'(pop_data_o), int'(m_rdd));
      check("R8 head tags", int'({head_par_o, head_frm_o, head_brk_o}), int'(exp_head()));
      check("R7 summary flag", int'(fifo_err_o), int'(m_err));
      check("R11 overrun", int'(overrun_o), int'(m_ovr));
   endtask

   task automatic model_update(input logic w, input logic [7:0] d, input logic [2:0] t,
                               input logic r, input logic s, input logic c);
      bit full = (m_cnt == 16);
      bit do_wr = w && !full && !c;
      bit do_rd = r && (m_cnt != 0) && !c;
      if (c) begin
         m_cnt = 0; m_tcnt = 0;
      end else begin
         if (do_rd) begin
            m_rdd = mq_d[0];
            if (mq_t[0] != 0) m_tcnt--;
            for (int i = 0; i < 15; i++) begin
               mq_d[i] = mq_d[i+1]; mq_t[i] = mq_t[i+1];
            end
            m_cnt--;
         end
         if (do_wr) begin
            mq_d[m_cnt] = d; mq_t[m_cnt] = t;
            if (t != 0) m_tcnt++;
            m_cnt++;
         end
      end
      if (w && full && !c) m_ovr = 1'b1;
      else if (s)          m_ovr = 1'b0;
      if (do_wr && t != 0)          m_err = 1'b1;
      else if (s && m_tcnt == 0)    m_err = 1'b0;
   endtask

   // drive at a falling edge, observe at the next falling edge
   task automatic step(input logic w, input logic [7:0] d, input logic p, input logic f,
                       input logic g, input logic b, input logic r, input logic s,
                       input logic c);
      push_i = w; push_data_i = d; push_par_i = p; push_frm_i = f;
      push_glitch_i = g; push_brk_i = b; pop_i = r; stat_rd_i = s; flush_i = c;
      @(posedge clk);
      @(negedge clk);
      model_update(w, d, {p, f | g, b}, r, s, c);
      check_all();
   endtask

   task automatic idle(); step(0, 8'h00, 0, 0, 0, 0, 0, 0, 0); endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A17));
      rst_n = 1'b0;
      flush_i = 0; push_i = 0; push_data_i = 0; push_par_i = 0; push_frm_i = 0;
      push_glitch_i = 0; push_brk_i = 0; pop_i = 0; stat_rd_i = 0;
      m_cnt = 0; m_tcnt = 0; m_err = 0; m_ovr = 0; m_rdd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12: reset state
      check("R12 level", int'(level_o), 0);
      check("R12 flags", int'({overrun_o, fifo_err_o}), 0);
      check("R12 data and tags", int'({pop_data_o, head_par_o, head_frm_o, head_brk_o}), 0);

      // R1: fill to capacity
      for (int i = 0; i < 16; i++) step(1, 8'(8'h30 + i), 0, 0, 0, 0, 0, 0, 0);
      check("R1 full level", int'(level_o), 16);
      // R2: seventeenth character is dropped
      step(1, 8'hEE, 0, 0, 0, 0, 0, 0, 0);
      check("R2 overrun set", int'(overrun_o), 1);
      check("R2 level kept", int'(level_o), 16);
      // R11: status read clears overrun
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, 0);
      check("R11 overrun cleared", int'(overrun_o), 0);
      // R3: drain in order
      for (int i = 0; i < 16; i++) begin
         step(0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
         check("R3 order", int'(pop_data_o), 8'h30 + i);
      end
      // R9: pop while empty
      step(0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
      check("R9 data held", int'(pop_data_o), 8'h3F);
      check("R9 level kept", int'(level_o), 0);
      // R4 / R6: glitch-only character becomes a framing tag
      step(1, 8'hA5, 0, 0, 1, 0, 0, 0, 0);
      check("R4 framing from glitch", int'(head_frm_o), 1);
      check("R6 summary set", int'(fifo_err_o), 1);
      // R7: read while the tagged entry is held keeps the flag
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, 0);
      check("R7 summary held", int'(fifo_err_o), 1);
      // R7: pop last tagged entry with a status read clears it
      step(0, 8'h00, 0, 0, 0, 0, 1, 1, 0);
      check("R7 summary cleared", int'(fifo_err_o), 0);
      // R10: push and pop together
      step(1, 8'h11, 0, 0, 0, 0, 0, 0, 0);
      step(1, 8'h22, 0, 0, 0, 1, 0, 0, 0);
      step(1, 8'h33, 0, 0, 0, 0, 1, 0, 0);
      check("R10 level kept", int'(level_o), 2);
      // R5: flush beats a same-cycle push, leaves the summary flag
      step(1, 8'h44, 1, 0, 0, 0, 0, 0, 1);
      check("R5 flushed", int'(level_o), 0);
      check("R5 summary untouched", int'(fifo_err_o), 1);
      idle();

      // random phase with a fill-biased and a drain-biased half of each period
      for (int n = 0; n < 4000; n++) begin
         int bias = ((n / 200) % 2 == 0) ? 3 : 1;
         logic w = ($urandom % 4) < bias;
         logic r = ($urandom % 4) < (4 - bias);
         step(w, 8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
              ($urandom % 16) == 0, ($urandom % 12) == 0, r,
              ($urandom % 6) == 0, ($urandom % 97) == 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule